// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA host channel during programmed I/O. A request comes with a direction and a class, either a data transfer or a task-file register access. The block then runs up to three timed phases: an optional setup phase, a phase with the selected strobe low, and a recovery phase with both strobes high. The length of every phase comes from a packed 32-bit timing word. Each field adds one clock to its own value, so a field of zero still lasts one cycle.

Data transfers and task-file accesses use separate sets of setup, strobe and recovery counts. The setup phase runs only at the start of a burst. It is skipped when a request has the same class as the previous access and the burst-start input is low. The timing word, direction and class are captured when a request is accepted, so later changes to those inputs do not affect an access already running. Busy marks the access, and a one-cycle done pulse marks its last cycle.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, rd_strobe_n and wr_strobe_n are 1, busy is 0 and done is 0.
- R2: For a data access (req_taskfile=0), the selected strobe is low for cfg_word[7:4]+1 consecutive cycles.
- R3: For a data access, both strobes stay high after the strobe phase for cfg_word[3:0]+1 cycles, and done is high in the last of those cycles.
- R4: For a task-file access (req_taskfile=1), the strobe is low for cfg_word[15:12]+1 cycles and the recovery lasts cfg_word[11:8]+1 cycles.
- R5: A data access that starts a burst first spends cfg_word[21:19]+1 cycles with busy high and both strobes high before its strobe falls.
- R6: A task-file access that starts a burst first spends cfg_word[24:22]+1 such setup cycles.
- R7: An access starts a burst, and so has a setup phase, when it is the first access after reset, when burst_start is 1 with the request, or when its class differs from the previous access. Otherwise it has no setup phase: the strobe falls in the first busy cycle.
- R8: A read (req_write=0) drives only rd_strobe_n low and a write (req_write=1) drives only wr_strobe_n low. The two strobes are never low in the same cycle.
- R9: cfg_word, req_write and req_taskfile are captured in the accepting cycle. Changing them while busy does not change the running access.
- R10: Bits 31 and 30 of cfg_word (bus-master PIO and FIFO enable) and all bits outside the timing fields have no effect on strobe timing.
- R11: A request is accepted on a clock edge where req_valid=1 and busy=0. Busy is high from the next cycle until done. Requests while busy are ignored.
- R12: Done is high for exactly one cycle per accepted access, and busy is 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data transfer |
| burst_start | input | 1 | Forces a setup phase for this request |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |

## Verification
The assertions assume that req_valid, req_write, req_taskfile, burst_start and cfg_word are stable around each rising edge and have known values once reset is released. They also assume the requester treats busy as its only flow control. The stimulus changes inputs only on falling edges. While busy is high it deliberately toggles req_valid and changes the word, direction and class, to show that those requests are dropped and the captured values are kept.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 4;
  localparam int SETUP_W = 3;

  // Bit positions inside the timing word
  localparam int DAT_REC_LSB = 0;
  localparam int DAT_STB_LSB = 4;
  localparam int TF_REC_LSB  = 8;
  localparam int TF_STB_LSB  = 12;
  localparam int DAT_SU_LSB  = 19;
  localparam int TF_SU_LSB   = 22;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } pio_phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] recover;
  } pio_times_t;

  function automatic pio_times_t pick_times(input logic [WORD_W-1:0] w,
                                            input logic              is_tf);
    pio_times_t t;
    if (is_tf) begin
      t.setup   = CNT_W'(w[TF_SU_LSB  +: SETUP_W]);
      t.strobe  = w[TF_STB_LSB +: CNT_W];
      t.recover = w[TF_REC_LSB +: CNT_W];
    end else begin
      t.setup   = CNT_W'(w[DAT_SU_LSB  +: SETUP_W]);
      t.strobe  = w[DAT_STB_LSB +: CNT_W];
      t.recover = w[DAT_REC_LSB +: CNT_W];
    end
    return t;
  endfunction

endpackage

// File: rtl/ata_pio_ctx.sv
module ata_pio_ctx
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              req_write,
  input  logic              req_taskfile,
  input  logic              burst_start,
  output logic              need_setup,
  output pio_times_t        live_times,
  output pio_times_t        held_times,
  output logic              write_q
);

  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic              write_d;
  logic              tf_q, tf_d;
  logic              seen_q, seen_d;

  // Next-state: capture context only on acceptance
  always_comb begin
    cfg_d   = cfg_q;
    write_d = write_q;
    tf_d    = tf_q;
    seen_d  = seen_q;
    if (accept) begin
      cfg_d   = cfg_word;
      write_d = req_write;
      tf_d    = req_taskfile;
      seen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      write_q <= 1'b0;
      tf_q    <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      write_q <= write_d;
      tf_q    <= tf_d;
      seen_q  <= seen_d;
    end
  end

  // A new burst begins on first use, on request, or on class change (R7)
  assign need_setup = burst_start | ~seen_q | (req_taskfile != tf_q);
  assign live_times = pick_times(cfg_word, req_taskfile);
  assign held_times = pick_times(cfg_q, tf_q);

  // R7: once an access has been accepted, the history flag never drops
  p_history_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);

endmodule

// File: rtl/ata_pio_ctr.sv
module ata_pio_ctr
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             need_setup,
  input  pio_times_t       live_times,
  input  pio_times_t       held_times,
  input  logic             write_q,
  input  logic             expired,
  output logic             accept,
  output logic             ld,
  output logic [CNT_W-1:0] ld_val,
  output logic             busy,
  output logic             done,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n
);

  pio_phase_e phase_q, phase_d;
  logic       write_nxt;
  logic       rd_n_d, wr_n_d;

  assign accept = req_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          ld = 1'b1;
          if (need_setup) begin
            phase_d = PH_SETUP;
            ld_val  = live_times.setup;
          end else begin
            phase_d = PH_STROBE;
            ld_val  = live_times.strobe;
          end
        end
      end
      PH_SETUP: begin
        if (expired) begin
          phase_d = PH_STROBE;
          ld      = 1'b1;
          ld_val  = held_times.strobe;
        end
      end
      PH_STROBE: begin
        if (expired) begin
          phase_d = PH_RECOVER;
          ld      = 1'b1;
          ld_val  = held_times.recover;
        end
      end
      PH_RECOVER: begin
        if (expired) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Strobes are registered from the next phase so they leave flops directly
  assign write_nxt = accept ? req_write : write_q;
  assign rd_n_d    = !((phase_d == PH_STROBE) && !write_nxt);
  assign wr_n_d    = !((phase_d == PH_STROBE) &&  write_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      rd_strobe_n <= 1'b1;
      wr_strobe_n <= 1'b1;
    end else begin
      phase_q     <= phase_d;
      rd_strobe_n <= rd_n_d;
      wr_strobe_n <= wr_n_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign done = (phase_q == PH_RECOVER) && expired;

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_n || wr_strobe_n);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_strobe_n && wr_strobe_n));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_strobe_fall_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_strobe_n) || $fell(wr_strobe_n)) |-> busy);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_taskfile,
  input  logic              burst_start,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n,
  output logic              busy,
  output logic              done
);

  logic             accept;
  logic             need_setup;
  logic             write_q;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;
  pio_times_t       live_times;
  pio_times_t       held_times;

  ata_pio_ctx u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cfg_word    (cfg_word),
    .req_write   (req_write),
    .req_taskfile(req_taskfile),
    .burst_start (burst_start),
    .need_setup  (need_setup),
    .live_times  (live_times),
    .held_times  (held_times),
    .write_q     (write_q)
  );

  ata_pio_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .need_setup (need_setup),
    .live_times (live_times),
    .held_times (held_times),
    .write_q    (write_q),
    .expired    (expired),
    .accept     (accept),
    .ld         (ld),
    .ld_val     (ld_val),
    .busy       (busy),
    .done       (done),
    .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n)
  );

  ata_pio_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .load_val(ld_val),
    .expired (expired)
  );

  // R9: captured timing stays fixed for the rest of a running access
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(held_times));

endmodule

// File: tb/sim_ata_pio_strobe_gen.sv
module sim_ata_pio_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        req_valid, req_write, req_taskfile, burst_start;
  logic        rd_strobe_n, wr_strobe_n, busy, done;

  always #2 clk = ~clk;

  ata_pio_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_write(req_write), .req_taskfile(req_taskfile), .burst_start(burst_start),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .busy(busy), .done(done)
  );

  typedef struct {
    bit wr;
    int su;
    int stb;
    int rec;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   n_pushed = 0;
  int   n_done   = 0;
  bit   seen_prev = 0;
  bit   prev_tf   = 0;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // Monitor: measures phase lengths and compares against the scoreboard
  int  m_su = 0, m_stb = 0, m_rec = 0;
  bit  m_wr = 0;
  bit  m_after_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_after_done) begin
        check(!busy && !done, "R12 busy/done after done", int'({busy, done}), 0);
        m_after_done = 0;
      end
      if (!rd_strobe_n && !wr_strobe_n)
        check(0, "R8 both strobes low", 1, 0);
      if (busy) begin
        if (!rd_strobe_n || !wr_strobe_n) begin
          m_stb++;
          m_wr = !wr_strobe_n;
        end else if (m_stb == 0) m_su++;
        else m_rec++;
        if (done) begin
          exp_t e;
          n_done++;
          m_after_done = 1;
          if (exp_q.size() == 0) begin
            check(0, "R11 unexpected access completed", 1, 0);
          end else begin
            e = exp_q.pop_front();
            check(m_su == e.su, "R5/R6/R7 setup cycles", m_su, e.su);
            check(m_stb == e.stb, "R2/R4 strobe cycles", m_stb, e.stb);
            check(m_rec == e.rec, "R3/R4 recovery cycles", m_rec, e.rec);
            check(m_wr == e.wr, "R8 strobe direction (1=write)", int'(m_wr), int'(e.wr));
          end
          m_su = 0; m_stb = 0; m_rec = 0;
        end
      end else if (done) begin
        check(0, "R12 done without busy", 1, 0);
      end
    end
  end

  // Driver: computes expected lengths from the requirement field map
  task automatic access(input logic [31:0] w, input bit wr, input bit tf,
                        input bit bs, input bit noisy);
    exp_t e;
    bit   su_needed;
    @(negedge clk);
    while (busy) @(negedge clk);
    su_needed = bs || !seen_prev || (tf != prev_tf);
    e.wr  = wr;
    if (tf) begin
      e.su  = su_needed ? int'(w[24:22]) + 1 : 0;
      e.stb = int'(w[15:12]) + 1;
      e.rec = int'(w[11:8]) + 1;
    end else begin
      e.su  = su_needed ? int'(w[21:19]) + 1 : 0;
      e.stb = int'(w[7:4]) + 1;
      e.rec = int'(w[3:0]) + 1;
    end
    exp_q.push_back(e);
    n_pushed++;
    seen_prev = 1;
    prev_tf   = tf;
    cfg_word = w; req_write = wr; req_taskfile = tf; burst_start = bs;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; burst_start = 1'b0;
    if (noisy) begin
      // R9/R11: scramble inputs and keep requesting while busy
      while (busy) begin
        cfg_word = ~w; req_write = ~wr; req_taskfile = ~tf;
        req_valid = 1'b1; burst_start = 1'b1;
        @(negedge clk);
      end
      req_valid = 1'b0; burst_start = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_word = '0; req_valid = 0; req_write = 0;
    req_taskfile = 0; burst_start = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_strobe_n && wr_strobe_n, "R1 strobes high in reset", int'({rd_strobe_n, wr_strobe_n}), 3);
    check(!busy && !done, "R1 busy/done low in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_strobe_n && wr_strobe_n && !busy && !done, "R1 idle after reset",
          int'({rd_strobe_n, wr_strobe_n, busy, done}), 12);

    // R2/R3/R5/R7: first data read starts a burst
    access(32'h0028_0532, 0, 0, 0, 0);
    // R7: same class, no burst start -> no setup
    access(32'h0028_0532, 0, 0, 0, 0);
    // R7/R8: burst_start forces setup, write strobe
    access(32'h0010_0547, 1, 0, 1, 0);
    // R4/R6/R7: class change to task-file
    access(32'h0140_6903, 0, 1, 0, 0);
    access(32'h0140_6903, 1, 1, 0, 0);
    // R7: back to data forces setup
    access(32'h0008_0021, 1, 0, 0, 0);
    // R9/R11: inputs scrambled and requests repeated while busy
    access(32'h0030_0a5c, 0, 0, 1, 1);
    access(32'h0280_3c47, 1, 1, 1, 1);
    // R10: ignored bits set, timing must equal the plain word
    access(32'hC000_0000 | 32'h0028_0532, 0, 0, 1, 0);
    access(32'hFE07_0000 | 32'h0140_6903, 1, 1, 1, 0);
    // Boundaries: all-zero and all-max fields
    access(32'h0000_0000, 0, 0, 1, 0);
    access(32'h0000_0000, 1, 1, 0, 0);
    access(32'h01F8_FFFF, 0, 1, 1, 0);
    access(32'h01F8_FFFF, 1, 0, 0, 0);
    // Mixed pseudo-random sequence
    begin
      logic [31:0] lfsr = 32'h1d87_2b41;
      for (int i = 0; i < 24; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        access(lfsr, lfsr[27], lfsr[26] & lfsr[25], lfsr[17], lfsr[16]);
      end
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11/R12 pending expected accesses", exp_q.size(), 0);
    check(n_done == n_pushed, "R11/R12 completed access count", n_done, n_pushed);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog expired, busy never settled actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule